// File: doc/BRIEF.md
# Segmented RAM Ternary Match Engine

This block gives ternary (value plus don't-care) rule matching without one comparator per stored bit. The search key is cut into equal slices. Each slice addresses a private synchronous RAM in which every word holds one bit per rule. That bit says whether the rule's slice accepts that slice value. The words read for all slices are ANDed, and a priority encoder then reports the lowest-numbered rule that matches. A caller uses that number to index its own action table.

Rules are loaded one at a time. The caller gives a rule number, a value and a care mask. A sweep controller then walks every address of the slice RAMs and rewrites only that rule's bit column in all RAMs at once. After reset the same controller clears every word, so that no rule matches until it is loaded. While either sweep runs, the block reports busy and does not accept search keys. Searches are pipelined: one key per clock, with a fixed three-cycle latency.

Top module: `tcam_emu`

## Requirements
- R1: After reset is released, busy stays high for exactly 2^SEG_W cycles while the tables are cleared. Once that ends and before any rule is loaded, every search reports hit = 0.
- R2: A key presented with srch_valid while busy is low produces one res_valid pulse three rising edges later. Keys may be presented on back-to-back cycles.
- R3: A rule matches a key when, for every key bit whose care bit is 1, the key bit equals the rule's value bit. Key bits whose care bit is 0 are ignored. Slice s covers key bits [s*SEG_W +: SEG_W].
- R4: When several rules match, res_index is the smallest matching rule number.
- R5: When no rule matches, res_valid is reported with res_hit = 0 and res_index = 0. res_hit is never high without res_valid.
- R6: upd_start taken while busy is low makes busy rise on the next cycle and stay high for exactly 2^SEG_W cycles. An upd_start given while busy is high is ignored: its rule is not written.
- R7: A key presented while busy is high is dropped and produces no res_valid.
- R8: Loading a rule replaces that rule's old value and mask and leaves every other rule's matching unchanged.
- R9: When srch_valid and upd_start arrive in the same idle cycle, the search completes against the rule set as it stood before the update.
- R10: A rule whose care mask is all zero matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_valid | input | 1 | Search key present |
| srch_key | input | KEY_W | Search key |
| upd_start | input | 1 | Start loading one rule |
| upd_rule | input | IDX_W | Rule number to load |
| upd_value | input | KEY_W | Rule value bits |
| upd_care | input | KEY_W | Rule care mask, 1 = bit compared |
| busy | output | 1 | Clear or load sweep in progress; keys refused |
| res_valid | output | 1 | Search result present |
| res_hit | output | 1 | At least one rule matched |
| res_index | output | IDX_W | Smallest matching rule number, 0 on miss |

## Verification
Two things can start in the same idle cycle: a search and a rule load. The bench provokes this by raising srch_valid and upd_start together. The key is chosen to miss on the old rule set and to hit the rule being loaded. The result must be a miss, and the same key searched once the sweep has ended must hit the new rule. The bench also drives keys and a second upd_start into the busy window. It then judges that no result appears, that busy lasts exactly one sweep, and that the ignored rule never matches.

// File: rtl/tcam_emu_pkg.sv
`timescale 1ns/1ps
// Shared types for the segmented RAM ternary match engine.
package tcam_emu_pkg;
    // Sweep controller modes: idle, table clear after reset, rule load.
    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_CLR  = 2'd1,
        CTL_LOAD = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/tcam_seg_ram.sv
`timescale 1ns/1ps
// One slice table: 2^ADDR_W words of DATA_W bits.
// Writes use a per-bit enable. Reads are registered with one cycle of latency.
// Assumes a read and a write to the same address never meet in one cycle,
// which the top guarantees by refusing keys during a sweep.
module tcam_seg_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wbit_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Per-bit masked write of the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < DATA_W; b++) begin
                if (wbit_en[b]) mem[waddr][b] <= wdata[b];
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tcam_sweep_ctl.sv
`timescale 1ns/1ps
// Sweep sequencer. After reset it walks every table address once in clear mode.
// When upd_start arrives while idle, it latches the rule and walks every
// address once in load mode. busy is high whenever a sweep runs.
module tcam_sweep_ctl
    import tcam_emu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int KEY_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  rule_in,
    input  logic [KEY_W-1:0]  value_in,
    input  logic [KEY_W-1:0]  care_in,
    output logic              busy,
    output logic              wr_en,
    output logic              wr_clear,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [IDX_W-1:0]  rule_q,
    output logic [KEY_W-1:0]  value_q,
    output logic [KEY_W-1:0]  care_q
);
    ctl_state_e        state;
    logic [ADDR_W-1:0] addr_q;

    // Mode and address sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CTL_CLR;
            addr_q <= '0;
        end else begin
            case (state)
                CTL_IDLE: if (start) begin
                    state  <= CTL_LOAD;
                    addr_q <= '0;
                end
                default: begin
                    addr_q <= addr_q + 1'b1;
                    if (&addr_q) state <= CTL_IDLE;
                end
            endcase
        end
    end

    // Capture the rule description when a load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_q  <= '0;
            value_q <= '0;
            care_q  <= '0;
        end else if (state == CTL_IDLE && start) begin
            rule_q  <= rule_in;
            value_q <= value_in;
            care_q  <= care_in;
        end
    end

    // Write strobes follow the mode.
    always_comb begin
        busy     = (state != CTL_IDLE);
        wr_en    = busy;
        wr_clear = (state == CTL_CLR);
        wr_addr  = addr_q;
    end
endmodule

// File: rtl/tcam_prio_enc.sv
`timescale 1ns/1ps
// Priority encoder: reports the lowest set bit of the vector.
// Returns index 0 and any = 0 when no bit is set.
module tcam_prio_enc #(
    parameter int WIDTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_emu.sv
`timescale 1ns/1ps
// Segmented RAM ternary match engine.
// The key is cut into KEY_W/SEG_W slices. Each slice reads a table whose word
// holds one match bit per rule. The words are ANDed and priority-encoded.
// Latency is three edges: table read, AND, encode.
// Assumes KEY_W is a multiple of SEG_W and that RULES is at least 2.
module tcam_emu #(
    parameter int KEY_W = 16,
    parameter int SEG_W = 4,
    parameter int RULES = 16,
    localparam int IDX_W = $clog2(RULES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_valid,
    input  logic [KEY_W-1:0] srch_key,
    input  logic             upd_start,
    input  logic [IDX_W-1:0] upd_rule,
    input  logic [KEY_W-1:0] upd_value,
    input  logic [KEY_W-1:0] upd_care,
    output logic             busy,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_index
);
    localparam int NSEG  = KEY_W / SEG_W;
    localparam int DEPTH = 1 << SEG_W;

    logic             wr_en, wr_clear;
    logic [SEG_W-1:0] wr_addr;
    logic [IDX_W-1:0] rule_q;
    logic [KEY_W-1:0] value_q, care_q;
    logic [RULES-1:0] col_en;
    logic [RULES-1:0] rd_word [NSEG];
    logic [RULES-1:0] match_c, match_q;
    logic             acc, v1, v2;
    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;

    tcam_sweep_ctl #(.ADDR_W(SEG_W), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(upd_start),
        .rule_in(upd_rule), .value_in(upd_value), .care_in(upd_care),
        .busy(busy), .wr_en(wr_en), .wr_clear(wr_clear), .wr_addr(wr_addr),
        .rule_q(rule_q), .value_q(value_q), .care_q(care_q)
    );

    // Column select: every bit during clear, only the loaded rule otherwise.
    always_comb begin
        col_en = wr_clear ? '1 : (RULES'(1) << rule_q);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic             seg_bit;
        logic [RULES-1:0] seg_wdata;

        // Does the loaded rule's slice accept the address under sweep?
        always_comb begin
            seg_bit   = ((wr_addr ^ value_q[s*SEG_W +: SEG_W])
                         & care_q[s*SEG_W +: SEG_W]) == '0;
            seg_wdata = wr_clear ? '0 : {RULES{seg_bit}};
        end

        tcam_seg_ram #(.ADDR_W(SEG_W), .DATA_W(RULES)) u_ram (
            .clk(clk), .we(wr_en), .waddr(wr_addr), .wbit_en(col_en),
            .wdata(seg_wdata), .raddr(srch_key[s*SEG_W +: SEG_W]),
            .rdata(rd_word[s])
        );
    end

    // Combine the slice words.
    always_comb begin
        match_c = '1;
        for (int s = 0; s < NSEG; s++) match_c &= rd_word[s];
    end

    assign acc = srch_valid && !busy;

    // Valid pipeline and AND stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1      <= 1'b0;
            v2      <= 1'b0;
            match_q <= '0;
        end else begin
            v1      <= acc;
            v2      <= v1;
            match_q <= match_c;
        end
    end

    tcam_prio_enc #(.WIDTH(RULES), .IDX_W(IDX_W)) u_enc (
        .vec(match_q), .any(enc_any), .idx(enc_idx)
    );

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
        end else begin
            res_valid <= v2;
            res_hit   <= v2 && enc_any;
            res_index <= (v2 && enc_any) ? enc_idx : '0;
        end
    end
endmodule

// File: rtl/tcam_emu_chk.sv
`timescale 1ns/1ps
// Checker for tcam_emu, attached with bind. It observes ports only.
// A counter measures each busy run, so that the length check needs no deep $past.
module tcam_emu_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_valid,
    input logic             upd_start,
    input logic             busy,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_index
);
    localparam int CW = $clog2(DEPTH) + 2;
    logic [CW-1:0] bcnt;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    AST_KEY_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid && !busy) |-> ##3 res_valid);                          // R2
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(srch_valid && !busy, 3));                      // R7
    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_index == '0));                    // R5
    AST_HIT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);                                            // R5
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_start && !busy) |=> busy);                                    // R6
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < CW'(DEPTH)));                                     // R6
    AST_BUSY_FULL_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == CW'(DEPTH)));                             // R1
endmodule

bind tcam_emu tcam_emu_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .upd_start(upd_start),
    .busy(busy), .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index)
);

// File: tb/test_tcam_emu.sv
`timescale 1ns/1ps
// Bench for tcam_emu. It loads four rules, walks a table of key vectors,
// then runs directed cases for reset, the busy window and same-cycle starts.
module test_tcam_emu;
    localparam int KEY_W = 16;
    localparam int SEG_W = 4;
    localparam int RULES = 16;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << SEG_W;
    localparam int NVEC  = 8;

    // Each entry is {key, expected hit, expected index}.
    localparam logic [20:0] VEC [NVEC] = '{
        {16'h1234, 1'b1, 4'd2},   // R3, R4: rules 2 and 5 both match
        {16'h1299, 1'b1, 4'd2},   // R3
        {16'hA123, 1'b1, 4'd7},   // R3
        {16'hA125, 1'b1, 4'd7},   // R4: rules 7 and 9 both match
        {16'h0005, 1'b1, 4'd9},   // R3
        {16'h1235, 1'b1, 4'd2},   // R4
        {16'hB000, 1'b0, 4'd0},   // R5
        {16'h5555, 1'b1, 4'd9}    // R3
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             srch_valid = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic             upd_start = 1'b0;
    logic [IDX_W-1:0] upd_rule = '0;
    logic [KEY_W-1:0] upd_value = '0;
    logic [KEY_W-1:0] upd_care = '0;
    logic             busy, res_valid, res_hit;
    logic [IDX_W-1:0] res_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tcam_emu #(.KEY_W(KEY_W), .SEG_W(SEG_W), .RULES(RULES)) i_tcam_emu (
        .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
        .upd_start(upd_start), .upd_rule(upd_rule), .upd_value(upd_value),
        .upd_care(upd_care), .busy(busy), .res_valid(res_valid),
        .res_hit(res_hit), .res_index(res_index)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic load_rule(input int r, input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
        upd_rule = IDX_W'(r); upd_value = v; upd_care = c; upd_start = 1'b1;
        @(negedge clk);
        upd_start = 1'b0;
        wait_idle();
    endtask

    // Present one key, then sample after the third edge.
    task automatic search(input logic [KEY_W-1:0] k, output logic v, output logic h,
                          output logic [IDX_W-1:0] idx);
        srch_key = k; srch_valid = 1'b1;
        @(negedge clk);
        srch_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        v = res_valid; h = res_hit; idx = res_index;
    endtask

    initial begin
        logic v, h;
        logic [IDX_W-1:0] idx;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: clearing sweep after reset
        check(busy == 1'b1, "R1 busy after reset", busy, 1);
        check(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == DEPTH, "R1 clear length", n, DEPTH);
        search(16'h0000, v, h, idx);
        check(v && !h, "R1 empty table misses", {v, h}, 2);

        load_rule(2, 16'h1200, 16'hFF00);
        load_rule(5, 16'h1234, 16'hFFFF);
        load_rule(7, 16'hA000, 16'hF000);
        load_rule(9, 16'h0005, 16'h000F);

        foreach (VEC[i]) begin
            search(VEC[i][20:5], v, h, idx);
            check(v == 1'b1, "R2 result valid", v, 1);
            check(h == VEC[i][4] && idx == VEC[i][3:0], "R3/R4/R5 vector",
                  {h, idx}, VEC[i][4:0]);
        end

        // R2: back-to-back keys, one result per cycle
        srch_key = 16'hA123; srch_valid = 1'b1; @(negedge clk);
        srch_key = 16'h0005; @(negedge clk);
        srch_valid = 1'b0; @(negedge clk);
        check(res_valid && res_index == 4'd7, "R2 first of pair", res_index, 7);
        @(negedge clk);
        check(res_valid && res_index == 4'd9, "R2 second of pair", res_index, 9);

        // R6, R7: keys and a second start during a load are dropped
        upd_rule = 4'd11; upd_value = 16'h0000; upd_care = 16'hFFFF; upd_start = 1'b1;
        @(negedge clk);
        upd_start = 1'b0;
        n = 0;
        for (int c = 0; c < DEPTH + 4; c++) begin
            if (c == 2) begin
                upd_rule = 4'd12; upd_value = 16'hB000; upd_care = 16'hFFFF; upd_start = 1'b1;
            end else upd_start = 1'b0;
            srch_valid = busy; srch_key = 16'hB000;
            if (res_valid) check(1'b0, "R7 result while busy", 1, 0);
            if (busy) n++;
            @(negedge clk);
        end
        srch_valid = 1'b0; upd_start = 1'b0;
        check(n == DEPTH, "R6 load length", n, DEPTH);
        search(16'hB000, v, h, idx);
        check(v && !h, "R6 ignored start left rule 12 unwritten", {h, idx}, 0);

        // R8: rewrite rule 2; rule 5 keeps matching
        load_rule(2, 16'hFFFF, 16'hFFFF);
        search(16'h1234, v, h, idx);
        check(h && idx == 4'd5, "R8 other rule preserved", idx, 5);
        search(16'h1299, v, h, idx);
        check(v && !h, "R8 old rule gone", {h, idx}, 0);

        // R9: search and start in the same idle cycle
        srch_key = 16'hB000; srch_valid = 1'b1;
        upd_rule = 4'd3; upd_value = 16'h0000; upd_care = 16'h0000; upd_start = 1'b1;
        @(negedge clk);
        srch_valid = 1'b0; upd_start = 1'b0;
        @(negedge clk); @(negedge clk);
        check(res_valid && !res_hit, "R9 search sees old rules", {res_hit, res_index}, 0);
        wait_idle();

        // R10: rule 3 now has no care bits
        search(16'hB000, v, h, idx);
        check(h && idx == 4'd3, "R10 all-don't-care matches", idx, 3);
        search(16'h0005, v, h, idx);
        check(h && idx == 4'd3, "R10 and R4 wins over rule 9", idx, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule